// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter Chain

This block keeps wall-clock time and calendar date as a chain of packed-BCD counters. The fields are seconds, minutes, hours (24-hour), weekday, day of month, month and two-digit year. The chain advances once for every cycle in which the one-pulse-per-second input `tick_i` is high. Each field that reaches its terminal count returns to its start value and carries into the next field. The length of the month depends on the month and, for February, on whether the year is a leap year. The weekday counter is driven by the midnight carry and has no other link to the date.

Software reaches every field through a small register port. A write strobe, a field address and a data byte load one field. The same address selects the byte shown on a combinational read port. Bit 7 of the seconds byte is a halt flag. It is set by reset, so the chain stays stopped until software clears it. Values outside the legal range are accepted when loaded. The rules for counting them out are fixed and listed below.

Top module: `bcd_cal_chain`

## Requirements
- R1: After reset the fields read: seconds 0x80 (halt set, count 00), minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00.
- R2: While seconds bit 7 (halt) is 1, `tick_i` changes no field. While it is 0, a tick cycle advances seconds by one, and the new value is readable after that clock edge.
- R3: Seconds and minutes go from 0x59 to 0x00 and carry into the next field. Hours go from 0x23 to 0x00 and carry into date and weekday.
- R4: Weekday (bits 2:0) counts up on each hours carry and goes from 7 to 1. It is not tied to date or month.
- R5: Date goes from the month's last day to 0x01 and carries into month. Months 0x04, 0x06, 0x09 and 0x11 end at 0x30. All other months end at 0x31. Month goes from 0x12 to 0x01 and carries into year. Year goes from 0x99 to 0x00.
- R6: February ends at 0x29 when the year's BCD value is a multiple of four (00 included), and at 0x28 otherwise.
- R7: Out-of-range rules. A field rolls to its start value when every bit set in its terminal value is also set in the field. A units digit wraps to 0 and carries into tens when its bits 3 and 0 are both set. On that carry, a tens digit greater than the terminal's tens digit becomes tens AND terminal tens; otherwise it increments. As a result, seconds loaded with 0x60 count up to 0x69 and then read 0x40, with no minutes carry.
- R8: In a cycle with both a write to a field and an increment of that field, the written value is stored.
- R9: Address map on `addr_i`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. Address 7 reads 0x00. Bits not held by a field read 0. The held bits are: seconds 7:0, minutes 6:0, hours 5:0, weekday 2:0, date 5:0, month 4:0, year 7:0.
- R10: `rdata_o` follows `addr_i` within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-per-second advance enable |
| wr_en_i | input | 1 | Field write strobe |
| addr_i | input | 3 | Field select for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Selected field, packed BCD |

## Verification
The bench builds the block with its default two-stage reset synchronizer. Every field has a fixed width, so no other parameter changes what can be reached. Loading a full timestamp before each single tick lets one pulse reach every rollover, including every month length and the leap-year cases. Keeping the halt and invalid-value tests at the seconds field keeps each out-of-range sequence a few ticks long.

// File: rtl/bcal_pkg.sv
package bcal_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int SEC_TW     = 3;
  localparam int MIN_TW     = 3;
  localparam int HOUR_TW    = 2;
  localparam int DATE_TW    = 2;
  localparam int MON_TW     = 1;
  localparam int YEAR_TW    = 4;
  localparam int DOW_W      = 3;

  typedef enum logic [ADDR_W-1:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DOW  = 3'd3,
    FLD_DATE = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_NONE = 3'd7
  } fld_e;

  localparam logic [4+SEC_TW-1:0]  SEC_TERM  = 7'h59;
  localparam logic [4+MIN_TW-1:0]  MIN_TERM  = 7'h59;
  localparam logic [4+HOUR_TW-1:0] HOUR_TERM = 6'h23;
  localparam logic [4+MON_TW-1:0]  MON_TERM  = 5'h12;
  localparam logic [4+YEAR_TW-1:0] YEAR_TERM = 8'h99;

  // BCD year is a multiple of four: even tens with units 0/4/8, odd tens with 2/6
  function automatic logic bcd_leap(input logic [7:0] yr);
    logic [3:0] u;
    u = yr[3:0];
    if (yr[4]) bcd_leap = (u == 4'd2) || (u == 4'd6);
    else       bcd_leap = (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
  endfunction

  function automatic logic [4+DATE_TW-1:0] last_day(input logic [4+MON_TW-1:0] mon,
                                                     input logic leap);
    case (mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcal_rst_sync.sv
module bcal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/bcal_bcd_field.sv
module bcal_bcd_field #(
  parameter int         TENS_W      = 3,
  parameter logic [3:0] START_UNITS = 4'd0,
  localparam int        VW          = 4 + TENS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          wr_i,
  input  logic [VW-1:0] wdata_i,
  input  logic [VW-1:0] term_i,
  output logic [VW-1:0] value_o,
  output logic          wrap_o
);
  logic [3:0]        units_q, units_d;
  logic [TENS_W-1:0] tens_q,  tens_d;
  logic [TENS_W-1:0] term_tens;
  logic              term_hit;
  logic              units_wrap;
  logic              ld;

  assign value_o    = {tens_q, units_q};
  assign term_tens  = term_i[VW-1:4];
  assign term_hit   = ((value_o & term_i) == term_i);
  assign units_wrap = ((units_q & 4'h9) == 4'h9);
  assign wrap_o     = inc_i & term_hit;
  assign ld         = wr_i | inc_i;

  always_comb begin
    units_d = units_q;
    tens_d  = tens_q;
    if (wr_i) begin
      units_d = wdata_i[3:0];
      tens_d  = wdata_i[VW-1:4];
    end else if (inc_i) begin
      if (term_hit) begin
        units_d = START_UNITS;
        tens_d  = '0;
      end else if (units_wrap) begin
        units_d = 4'd0;
        if (tens_q > term_tens) tens_d = tens_q & term_tens;
        else                    tens_d = tens_q + TENS_W'(1);
      end else begin
        units_d = units_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units_q <= START_UNITS;
      tens_q  <= '0;
    end else if (ld) begin
      units_q <= units_d;
      tens_q  <= tens_d;
    end
  end

  // R8: a write in the same cycle as an increment is what gets stored
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (value_o == $past(wdata_i)));

  // R7: a terminal match rolls the field to its start value
  a_r7_roll_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_i && term_hit) |=> (value_o == VW'(START_UNITS)));

  // R2: with no increment and no write the field holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !wr_i) |=> $stable(value_o));
endmodule

// File: rtl/bcal_dow.sv
module bcal_dow #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] LAST  = '1;
  localparam logic [W-1:0] FIRST = W'(1);

  logic [W-1:0] dow_q, dow_d;
  logic         ld;

  assign ld      = wr_i | inc_i;
  assign value_o = dow_q;

  always_comb begin
    dow_d = dow_q;
    if (wr_i)                 dow_d = wdata_i;
    else if (dow_q == LAST)   dow_d = FIRST;
    else                      dow_d = dow_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dow_q <= FIRST;
    else if (ld) dow_q <= dow_d;
  end

  // R4: weekday leaves 7 for 1
  a_r4_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_i && dow_q == LAST) |=> (dow_q == FIRST));
endmodule

// File: rtl/bcd_cal_chain.sv
module bcd_cal_chain
  import bcal_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NREG = 1 << ADDR_W;

  logic rst_n_s;
  logic halt_q, halt_d, halt_ld;
  logic step;
  logic wr_sec, wr_min, wr_hour, wr_dow, wr_date, wr_mon, wr_year;
  logic sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap, year_wrap;

  logic [4+SEC_TW-1:0]  sec_v;
  logic [4+MIN_TW-1:0]  min_v;
  logic [4+HOUR_TW-1:0] hour_v;
  logic [DOW_W-1:0]     dow_v;
  logic [4+DATE_TW-1:0] date_v, date_term;
  logic [4+MON_TW-1:0]  mon_v;
  logic [4+YEAR_TW-1:0] year_v;
  logic [DATA_W-1:0]    regs [NREG];

  bcal_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  assign wr_sec  = wr_en_i && (addr_i == FLD_SEC);
  assign wr_min  = wr_en_i && (addr_i == FLD_MIN);
  assign wr_hour = wr_en_i && (addr_i == FLD_HOUR);
  assign wr_dow  = wr_en_i && (addr_i == FLD_DOW);
  assign wr_date = wr_en_i && (addr_i == FLD_DATE);
  assign wr_mon  = wr_en_i && (addr_i == FLD_MON);
  assign wr_year = wr_en_i && (addr_i == FLD_YEAR);

  // halt flag in bit 7 of seconds; set by reset
  assign halt_ld = wr_sec;
  assign halt_d  = wdata_i[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     halt_q <= 1'b1;
    else if (halt_ld) halt_q <= halt_d;
  end

  assign step      = tick_i & ~halt_q;
  assign date_term = last_day(mon_v, bcd_leap(year_v));

  bcal_bcd_field #(.TENS_W(SEC_TW), .START_UNITS(4'd0)) u_sec (
    .clk(clk), .rst_n(rst_n_s), .inc_i(step), .wr_i(wr_sec),
    .wdata_i(wdata_i[4+SEC_TW-1:0]), .term_i(SEC_TERM),
    .value_o(sec_v), .wrap_o(sec_wrap)
  );

  bcal_bcd_field #(.TENS_W(MIN_TW), .START_UNITS(4'd0)) u_min (
    .clk(clk), .rst_n(rst_n_s), .inc_i(sec_wrap), .wr_i(wr_min),
    .wdata_i(wdata_i[4+MIN_TW-1:0]), .term_i(MIN_TERM),
    .value_o(min_v), .wrap_o(min_wrap)
  );

  bcal_bcd_field #(.TENS_W(HOUR_TW), .START_UNITS(4'd0)) u_hour (
    .clk(clk), .rst_n(rst_n_s), .inc_i(min_wrap), .wr_i(wr_hour),
    .wdata_i(wdata_i[4+HOUR_TW-1:0]), .term_i(HOUR_TERM),
    .value_o(hour_v), .wrap_o(hour_wrap)
  );

  bcal_dow #(.W(DOW_W)) u_dow (
    .clk(clk), .rst_n(rst_n_s), .inc_i(hour_wrap), .wr_i(wr_dow),
    .wdata_i(wdata_i[DOW_W-1:0]), .value_o(dow_v)
  );

  bcal_bcd_field #(.TENS_W(DATE_TW), .START_UNITS(4'd1)) u_date (
    .clk(clk), .rst_n(rst_n_s), .inc_i(hour_wrap), .wr_i(wr_date),
    .wdata_i(wdata_i[4+DATE_TW-1:0]), .term_i(date_term),
    .value_o(date_v), .wrap_o(date_wrap)
  );

  bcal_bcd_field #(.TENS_W(MON_TW), .START_UNITS(4'd1)) u_mon (
    .clk(clk), .rst_n(rst_n_s), .inc_i(date_wrap), .wr_i(wr_mon),
    .wdata_i(wdata_i[4+MON_TW-1:0]), .term_i(MON_TERM),
    .value_o(mon_v), .wrap_o(mon_wrap)
  );

  bcal_bcd_field #(.TENS_W(YEAR_TW), .START_UNITS(4'd0)) u_year (
    .clk(clk), .rst_n(rst_n_s), .inc_i(mon_wrap), .wr_i(wr_year),
    .wdata_i(wdata_i[4+YEAR_TW-1:0]), .term_i(YEAR_TERM),
    .value_o(year_v), .wrap_o(year_wrap)
  );

  // read view: unheld bits are zero
  always_comb begin
    for (int i = 0; i < NREG; i++) regs[i] = '0;
    regs[FLD_SEC]  = {halt_q, sec_v};
    regs[FLD_MIN]  = DATA_W'(min_v);
    regs[FLD_HOUR] = DATA_W'(hour_v);
    regs[FLD_DOW]  = DATA_W'(dow_v);
    regs[FLD_DATE] = DATA_W'(date_v);
    regs[FLD_MON]  = DATA_W'(mon_v);
    regs[FLD_YEAR] = DATA_W'(year_v);
  end

  assign rdata_o = regs[addr_i];

  // R2: while halted and not written, seconds keep their count
  a_r2_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n_s)
    (halt_q && !wr_en_i) |=> $stable(sec_v));

  // R3: a midnight carry leaves hours at zero
  a_r3_midnight: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hour_wrap && !wr_hour) |=> (hour_v == '0));

  // R5: a year carry leaves the year at zero
  a_r5_year_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (year_wrap && !wr_year) |=> (year_v == '0));

  // R9: address 7 never reads data
  always_comb begin
    a_r9_hole_zero: assert (addr_i != FLD_NONE || rdata_o == '0);
  end
endmodule

// File: tb/test_bcd_cal_chain.sv
module test_bcd_cal_chain;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i;
  logic       wr_en_i;
  logic [2:0] addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_cal_chain i_bcd_cal_chain (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  // each entry: start {sec,min,hour,dow,date,mon,year}, expected after one tick
  localparam logic [111:0] VEC [NV] = '{
    {8'h00,8'h00,8'h00,8'h03,8'h15,8'h06,8'h21, 8'h01,8'h00,8'h00,8'h03,8'h15,8'h06,8'h21},
    {8'h59,8'h34,8'h12,8'h03,8'h15,8'h06,8'h21, 8'h00,8'h35,8'h12,8'h03,8'h15,8'h06,8'h21},
    {8'h59,8'h59,8'h12,8'h03,8'h15,8'h06,8'h21, 8'h00,8'h00,8'h13,8'h03,8'h15,8'h06,8'h21},
    {8'h59,8'h59,8'h23,8'h07,8'h15,8'h06,8'h21, 8'h00,8'h00,8'h00,8'h01,8'h16,8'h06,8'h21},
    {8'h59,8'h59,8'h23,8'h02,8'h30,8'h04,8'h21, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h05,8'h21},
    {8'h59,8'h59,8'h23,8'h02,8'h30,8'h05,8'h21, 8'h00,8'h00,8'h00,8'h03,8'h31,8'h05,8'h21},
    {8'h59,8'h59,8'h23,8'h05,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h01,8'h00},
    {8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h23},
    {8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h24},
    {8'h59,8'h59,8'h23,8'h01,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h24},
    {8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h00},
    {8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h12, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h12},
    {8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h10, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h10},
    {8'h59,8'h59,8'h23,8'h04,8'h30,8'h09,8'h21, 8'h00,8'h00,8'h00,8'h05,8'h01,8'h10,8'h21},
    {8'h59,8'h59,8'h23,8'h06,8'h31,8'h01,8'h21, 8'h00,8'h00,8'h00,8'h07,8'h01,8'h02,8'h21}
  };

  function automatic string vec_req(input int i);
    case (i)
      0:              vec_req = "R2";
      1, 2:           vec_req = "R3";
      3, 14:          vec_req = "R4";
      4, 5, 6, 13:    vec_req = "R5";
      default:        vec_req = "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values, R9 hole address
    rd_chk(3'd0, 8'h80, "R1 sec");
    rd_chk(3'd1, 8'h00, "R1 min");
    rd_chk(3'd2, 8'h00, "R1 hour");
    rd_chk(3'd3, 8'h01, "R1 dow");
    rd_chk(3'd4, 8'h01, "R1 date");
    rd_chk(3'd5, 8'h01, "R1 month");
    rd_chk(3'd6, 8'h00, "R1 year");
    rd_chk(3'd7, 8'h00, "R9 addr7");

    // R2 halted after reset: ticks ignored
    tick(3);
    rd_chk(3'd0, 8'h80, "R2 halted");
    wr(3'd0, 8'h00);
    tick(1);
    rd_chk(3'd0, 8'h01, "R2 running");

    // vector table
    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < 7; f++) wr(3'(f), VEC[v][111-8*f -: 8]);
      tick(1);
      for (int f = 0; f < 7; f++)
        rd_chk(3'(f), VEC[v][55-8*f -: 8], $sformatf("%s vec%0d fld%0d", vec_req(v), v, f));
    end

    // R7 invalid seconds 0x60 -> 0x69 -> 0x40, no minutes carry
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h60);
    tick(9);
    rd_chk(3'd0, 8'h69, "R7 sec 69");
    tick(1);
    rd_chk(3'd0, 8'h40, "R7 sec 40");
    rd_chk(3'd1, 8'h10, "R7 min no carry");
    // R7 invalid units 0x0A -> 0x0B -> 0x10
    wr(3'd0, 8'h0A);
    tick(1);
    rd_chk(3'd0, 8'h0B, "R7 units B");
    tick(1);
    rd_chk(3'd0, 8'h10, "R7 units wrap");

    // R8 write and tick in the same cycle
    wr(3'd0, 8'h24);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 3'd0; wdata_i = 8'h30; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    rd_chk(3'd0, 8'h30, "R8 write wins");

    // R2 halt set by software stops counting
    wr(3'd0, 8'h85);
    tick(3);
    rd_chk(3'd0, 8'h85, "R2 halt set");

    // R9 unused bits read zero
    wr(3'd1, 8'hFF); rd_chk(3'd1, 8'h7F, "R9 min bits");
    wr(3'd2, 8'hFF); rd_chk(3'd2, 8'h3F, "R9 hour bits");
    wr(3'd3, 8'hFF); rd_chk(3'd3, 8'h07, "R9 dow bits");
    wr(3'd4, 8'hFF); rd_chk(3'd4, 8'h3F, "R9 date bits");
    wr(3'd5, 8'hFF); rd_chk(3'd5, 8'h1F, "R9 month bits");

    // R10 read follows address without a clock edge
    wr(3'd1, 8'h42);
    wr(3'd6, 8'h37);
    @(negedge clk);
    addr_i = 3'd1; #1; chk("R10 addr1", rdata_o, 8'h42);
    addr_i = 3'd6; #1; chk("R10 addr6", rdata_o, 8'h37);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule